// File: doc/BRIEF.md
# Staggered Double-Pumped Integer Adder

This block adds or subtracts two 32-bit integers. It runs on a fast clock at twice the core rate and splits the carry chain across pipeline stages. In the first fast cycle it forms the low 16-bit slice. In the second it forms the high slice, using the registered carry out of the low slice. A third stage produces the zero, carry, sign and overflow flags. The complete result with its flags therefore arrives three fast cycles after issue, which is one and a half core cycles.

Each half of the result is forwarded as soon as it is registered. An operation issued on the next fast cycle can take the previous result as its A operand. Its low slice reads the forwarded low half. One cycle later, its high slice reads the forwarded high half. Chains of dependent adds therefore issue on every fast cycle with no bubbles.

The fast clock is the only clock. The core-rate phase comes in as a level input. It is carried alongside each operation, so that the consumer knows which core half-cycle issued it.

Top module: `staggered_adder`

## Requirements
- R1: While reset is asserted and after its release with no issue, all valid outputs, `res`, `res_ph` and all four flags are 0.
- R2: An operation issued with `in_valid`=1 at edge k shows its low 16 result bits on `fwd_lo`, with `fwd_lo_valid`=1, for the cycle after edge k.
- R3: The high 16 result bits, including the carry out of the low slice, appear on `fwd_hi` with `fwd_hi_valid`=1 for the cycle after edge k+1.
- R4: The full 32-bit result appears on `res` with `res_valid`=1 for the cycle after edge k+2, which is three fast cycles after issue.
- R5: `in_sub`=0 selects A+B and `in_sub`=1 selects A-B, both modulo 2^32. Subtraction inverts B and feeds a carry-in of 1 into the low slice.
- R6: With `in_fwd`=1, operand A is the result of the operation issued on the immediately preceding fast cycle, which must have been valid. `in_a` is then ignored. Dependent operations may issue on every cycle.
- R7: `flag_zero` is 1 exactly when both result halves are zero.
- R8: `flag_carry` is the carry out of bit 31 of A + (B or ~B) + carry-in. For a subtract, 1 means no borrow.
- R9: `flag_sign` equals result bit 31.
- R10: `flag_ovf` is 1 when the signed two's-complement result does not fit in 32 bits, for both add and subtract.
- R11: `res_ph` returns the `core_ph` value that was present when the operation issued.
- R12: A new operation is accepted on every fast cycle, and idle cycles (`in_valid`=0) produce no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast (double-rate) clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_ph | input | 1 | Core-rate phase level, tagged onto each issue |
| in_valid | input | 1 | Issue strobe |
| in_sub | input | 1 | 0 add, 1 subtract |
| in_fwd | input | 1 | Take operand A from the previous operation's result |
| in_a | input | 32 | Operand A |
| in_b | input | 32 | Operand B |
| fwd_lo_valid | output | 1 | Low forwarded half valid |
| fwd_lo | output | 16 | Low half of result, one cycle after issue |
| fwd_hi_valid | output | 1 | High forwarded half valid |
| fwd_hi | output | 16 | High half of result, two cycles after issue |
| res_valid | output | 1 | Full result valid |
| res | output | 32 | Full result |
| res_ph | output | 1 | Core phase tag of the result |
| flag_zero | output | 1 | Result is zero |
| flag_carry | output | 1 | Carry out of bit 31 |
| flag_sign | output | 1 | Result bit 31 |
| flag_ovf | output | 1 | Signed overflow |

## Verification
The bench targets carries that ripple out of the low slice into the high slice, such as 0x0000FFFF+1. A design that dropped or mistimed the registered carry would produce a wrong upper half there. It runs back-to-back dependent chains in which each operation forwards into the next. A design that read the high half one cycle early or late would mix results from adjacent operations. Subtracts with equal operands, borrows and signed extremes (0x7FFFFFFF+1, 0x80000000-1) expose inverted carry polarity, a zero flag taken from one half only, and an overflow rule that ignores the inverted B sign.

// File: rtl/staggered_adder_pkg.sv
package staggered_adder_pkg;

  typedef struct packed {
    logic zero;
    logic carry;
    logic sign;
    logic ovf;
  } sa_flags_t;

  // Signed overflow: the two effective operand signs agree and the result sign differs.
  function automatic logic sa_ovf(input logic sign_a, input logic sign_b, input logic sign_r);
    return (sign_a == sign_b) && (sign_r != sign_a);
  endfunction

endpackage

// File: rtl/sa_lo_stage.sv
module sa_lo_stage #(
  parameter int DATA_W = 32,
  localparam int HALF = DATA_W / 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            iss_v,
  input  logic            iss_sub,
  input  logic            iss_fwd,
  input  logic [DATA_W-1:0] iss_a,
  input  logic [DATA_W-1:0] iss_b,
  input  logic            iss_ph,
  output logic            v_q,
  output logic [HALF-1:0] lo_q,
  output logic            c_q,
  output logic [HALF-1:0] ahi_q,
  output logic [HALF-1:0] bhi_q,
  output logic            fwd_q,
  output logic            ph_q
);

  function automatic logic [HALF:0] add_slice(input logic [HALF-1:0] x,
                                              input logic [HALF-1:0] y,
                                              input logic ci);
    return {1'b0, x} + {1'b0, y} + {{HALF{1'b0}}, ci};
  endfunction

  logic [DATA_W-1:0] b_eff;
  logic [HALF-1:0]   a_lo;
  logic [HALF:0]     lo_sum;

  always_comb begin
    b_eff  = iss_sub ? ~iss_b : iss_b;
    a_lo   = iss_fwd ? lo_q : iss_a[HALF-1:0];
    lo_sum = add_slice(a_lo, b_eff[HALF-1:0], iss_sub);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q   <= 1'b0;
      lo_q  <= '0;
      c_q   <= 1'b0;
      ahi_q <= '0;
      bhi_q <= '0;
      fwd_q <= 1'b0;
      ph_q  <= 1'b0;
    end else begin
      v_q <= iss_v;
      if (iss_v) begin
        lo_q  <= lo_sum[HALF-1:0];
        c_q   <= lo_sum[HALF];
        ahi_q <= iss_a[DATA_W-1:HALF];
        bhi_q <= b_eff[DATA_W-1:HALF];
        fwd_q <= iss_fwd;
        ph_q  <= iss_ph;
      end
    end
  end

endmodule

// File: rtl/sa_hi_stage.sv
module sa_hi_stage #(
  parameter int DATA_W = 32,
  localparam int HALF = DATA_W / 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            v_in,
  input  logic [HALF-1:0] lo_in,
  input  logic            c_in,
  input  logic [HALF-1:0] ahi_in,
  input  logic [HALF-1:0] bhi_in,
  input  logic            fwd_in,
  input  logic            ph_in,
  output logic            v_q,
  output logic [HALF-1:0] lo_q,
  output logic [HALF-1:0] hi_q,
  output logic            c_q,
  output logic            sa_q,
  output logic            sb_q,
  output logic            ph_q
);

  function automatic logic [HALF:0] add_slice(input logic [HALF-1:0] x,
                                              input logic [HALF-1:0] y,
                                              input logic ci);
    return {1'b0, x} + {1'b0, y} + {{HALF{1'b0}}, ci};
  endfunction

  logic [HALF-1:0] a_hi;
  logic [HALF:0]   hi_sum;

  always_comb begin
    a_hi   = fwd_in ? hi_q : ahi_in;
    hi_sum = add_slice(a_hi, bhi_in, c_in);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q  <= 1'b0;
      lo_q <= '0;
      hi_q <= '0;
      c_q  <= 1'b0;
      sa_q <= 1'b0;
      sb_q <= 1'b0;
      ph_q <= 1'b0;
    end else begin
      v_q <= v_in;
      if (v_in) begin
        lo_q <= lo_in;
        hi_q <= hi_sum[HALF-1:0];
        c_q  <= hi_sum[HALF];
        sa_q <= a_hi[HALF-1];
        sb_q <= bhi_in[HALF-1];
        ph_q <= ph_in;
      end
    end
  end

endmodule

// File: rtl/sa_flag_stage.sv
module sa_flag_stage
  import staggered_adder_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int HALF = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              v_in,
  input  logic [HALF-1:0]   lo_in,
  input  logic [HALF-1:0]   hi_in,
  input  logic              c_in,
  input  logic              sa_in,
  input  logic              sb_in,
  input  logic              ph_in,
  output logic              v_q,
  output logic [DATA_W-1:0] res_q,
  output sa_flags_t         flags_q,
  output logic              ph_q
);

  sa_flags_t flags_d;

  always_comb begin
    flags_d.zero  = (lo_in == '0) && (hi_in == '0);
    flags_d.carry = c_in;
    flags_d.sign  = hi_in[HALF-1];
    flags_d.ovf   = sa_ovf(sa_in, sb_in, hi_in[HALF-1]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q     <= 1'b0;
      res_q   <= '0;
      flags_q <= '0;
      ph_q    <= 1'b0;
    end else begin
      v_q <= v_in;
      if (v_in) begin
        res_q   <= {hi_in, lo_in};
        flags_q <= flags_d;
        ph_q    <= ph_in;
      end
    end
  end

endmodule

// File: rtl/staggered_adder.sv
module staggered_adder
  import staggered_adder_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int HALF = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_ph,
  input  logic              in_valid,
  input  logic              in_sub,
  input  logic              in_fwd,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic              fwd_lo_valid,
  output logic [HALF-1:0]   fwd_lo,
  output logic              fwd_hi_valid,
  output logic [HALF-1:0]   fwd_hi,
  output logic              res_valid,
  output logic [DATA_W-1:0] res,
  output logic              res_ph,
  output logic              flag_zero,
  output logic              flag_carry,
  output logic              flag_sign,
  output logic              flag_ovf
);

  // Named inter-stage events
  logic            s1_v, s1_c, s1_fwd, s1_ph;
  logic [HALF-1:0] s1_lo, s1_ahi, s1_bhi;
  logic            s2_v, s2_c, s2_sa, s2_sb, s2_ph;
  logic [HALF-1:0] s2_lo, s2_hi;
  sa_flags_t       s3_flags;

  sa_lo_stage #(.DATA_W(DATA_W)) u_lo (
    .clk(clk), .rst_n(rst_n), .iss_v(in_valid), .iss_sub(in_sub), .iss_fwd(in_fwd),
    .iss_a(in_a), .iss_b(in_b), .iss_ph(core_ph),
    .v_q(s1_v), .lo_q(s1_lo), .c_q(s1_c), .ahi_q(s1_ahi), .bhi_q(s1_bhi),
    .fwd_q(s1_fwd), .ph_q(s1_ph)
  );

  sa_hi_stage #(.DATA_W(DATA_W)) u_hi (
    .clk(clk), .rst_n(rst_n), .v_in(s1_v), .lo_in(s1_lo), .c_in(s1_c),
    .ahi_in(s1_ahi), .bhi_in(s1_bhi), .fwd_in(s1_fwd), .ph_in(s1_ph),
    .v_q(s2_v), .lo_q(s2_lo), .hi_q(s2_hi), .c_q(s2_c), .sa_q(s2_sa),
    .sb_q(s2_sb), .ph_q(s2_ph)
  );

  sa_flag_stage #(.DATA_W(DATA_W)) u_flag (
    .clk(clk), .rst_n(rst_n), .v_in(s2_v), .lo_in(s2_lo), .hi_in(s2_hi),
    .c_in(s2_c), .sa_in(s2_sa), .sb_in(s2_sb), .ph_in(s2_ph),
    .v_q(res_valid), .res_q(res), .flags_q(s3_flags), .ph_q(res_ph)
  );

  assign fwd_lo_valid = s1_v;
  assign fwd_lo       = s1_lo;
  assign fwd_hi_valid = s2_v;
  assign fwd_hi       = s2_hi;
  assign flag_zero    = s3_flags.zero;
  assign flag_carry   = s3_flags.carry;
  assign flag_sign    = s3_flags.sign;
  assign flag_ovf     = s3_flags.ovf;

endmodule

// File: rtl/staggered_adder_chk.sv
module staggered_adder_chk #(
  parameter int DATA_W = 32,
  localparam int HALF = DATA_W / 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_ph,
  input logic              in_valid,
  input logic              fwd_lo_valid,
  input logic [HALF-1:0]   fwd_lo,
  input logic              fwd_hi_valid,
  input logic [HALF-1:0]   fwd_hi,
  input logic              res_valid,
  input logic [DATA_W-1:0] res,
  input logic              res_ph,
  input logic              flag_zero
);

  AST_LO_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_lo_valid == $past(in_valid)); // R2
  AST_HI_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_hi_valid == $past(fwd_lo_valid)); // R3
  AST_RES_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid == $past(in_valid, 3)); // R4
  AST_RES_LO_FROM_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res[HALF-1:0] == $past(fwd_lo, 2)); // R2
  AST_RES_HI_FROM_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res[DATA_W-1:HALF] == $past(fwd_hi)); // R3
  AST_ZERO_BOTH_HALVES: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> flag_zero == (res == '0)); // R7
  AST_PHASE_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_ph == $past(core_ph, 3)); // R11

endmodule

bind staggered_adder staggered_adder_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .core_ph(core_ph), .in_valid(in_valid),
  .fwd_lo_valid(fwd_lo_valid), .fwd_lo(fwd_lo), .fwd_hi_valid(fwd_hi_valid),
  .fwd_hi(fwd_hi), .res_valid(res_valid), .res(res), .res_ph(res_ph),
  .flag_zero(flag_zero)
);

// File: tb/test_staggered_adder.sv
module test_staggered_adder;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, core_ph, in_valid, in_sub, in_fwd;
  logic [31:0] in_a, in_b;
  logic fwd_lo_valid, fwd_hi_valid, res_valid, res_ph;
  logic [15:0] fwd_lo, fwd_hi;
  logic [31:0] res;
  logic flag_zero, flag_carry, flag_sign, flag_ovf;

  int checks = 0;
  int errors = 0;
  int n = 0;
  bit done = 0;

  logic        ev [4];
  logic [31:0] er [4];
  logic [3:0]  ef [4];
  logic        ep [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  staggered_adder i_staggered_adder (
    .clk(clk), .rst_n(rst_n), .core_ph(core_ph), .in_valid(in_valid),
    .in_sub(in_sub), .in_fwd(in_fwd), .in_a(in_a), .in_b(in_b),
    .fwd_lo_valid(fwd_lo_valid), .fwd_lo(fwd_lo), .fwd_hi_valid(fwd_hi_valid),
    .fwd_hi(fwd_hi), .res_valid(res_valid), .res(res), .res_ph(res_ph),
    .flag_zero(flag_zero), .flag_carry(flag_carry), .flag_sign(flag_sign),
    .flag_ovf(flag_ovf)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (step %0d)", tag, act, exp, n);
    end
  endtask

  // Returns {zero,carry,sign,ovf} and the result, computed by wide arithmetic.
  function automatic logic [35:0] model(input logic [31:0] a, input logic [31:0] b, input logic sub);
    logic [32:0] w;
    logic [31:0] r;
    logic ov;
    w  = sub ? ({1'b0, a} + {1'b0, ~b} + 33'd1) : ({1'b0, a} + {1'b0, b});
    r  = w[31:0];
    ov = sub ? ((a[31] != b[31]) && (r[31] != a[31])) : ((a[31] == b[31]) && (r[31] != a[31]));
    return {(r == 32'd0), w[32], r[31], ov, r};
  endfunction

  task automatic step(input logic v, input logic sub, input logic fwd,
                      input logic [31:0] a, input logic [31:0] b);
    int s1, s2, s3, s0;
    logic [31:0] aa;
    logic [35:0] m;
    @(negedge clk);
    s0 = n & 3; s1 = (n + 3) & 3; s2 = (n + 2) & 3; s3 = (n + 1) & 3;
    chk("R2 lo valid", {31'd0, fwd_lo_valid}, {31'd0, ev[s1]});
    if (ev[s1]) chk("R2 lo half", {16'd0, fwd_lo}, {16'd0, er[s1][15:0]});
    chk("R3 hi valid", {31'd0, fwd_hi_valid}, {31'd0, ev[s2]});
    if (ev[s2]) chk("R3 hi half", {16'd0, fwd_hi}, {16'd0, er[s2][31:16]});
    chk("R12 res valid", {31'd0, res_valid}, {31'd0, ev[s3]});
    if (ev[s3]) begin
      chk("R4 R5 R6 result", res, er[s3]);
      chk("R7 zero", {31'd0, flag_zero}, {31'd0, ef[s3][3]});
      chk("R8 carry", {31'd0, flag_carry}, {31'd0, ef[s3][2]});
      chk("R9 sign", {31'd0, flag_sign}, {31'd0, ef[s3][1]});
      chk("R10 ovf", {31'd0, flag_ovf}, {31'd0, ef[s3][0]});
      chk("R11 phase", {31'd0, res_ph}, {31'd0, ep[s3]});
    end
    aa = (fwd && ev[s1]) ? er[s1] : a;
    m  = model(aa, b, sub);
    ev[s0] = v;
    er[s0] = m[31:0];
    ef[s0] = m[35:32];
    ep[s0] = n[0];
    in_valid = v; in_sub = sub; in_fwd = fwd && ev[s1];
    in_a = a; in_b = b; core_ph = n[0];
    n++;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 4; i++) begin ev[i] = 0; er[i] = 0; ef[i] = 0; ep[i] = 0; end
    rst_n = 0; core_ph = 0; in_valid = 0; in_sub = 0; in_fwd = 0; in_a = 0; in_b = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset valids", {29'd0, fwd_lo_valid, fwd_hi_valid, res_valid}, 32'd0);
    chk("R1 reset res", res, 32'd0);
    chk("R1 reset flags", {27'd0, res_ph, flag_zero, flag_carry, flag_sign, flag_ovf}, 32'd0);
    rst_n = 1;
    // directed corner cases
    step(1, 0, 0, 32'h0000_0000, 32'h0000_0000);   // R7 zero without carry
    step(1, 0, 0, 32'hFFFF_FFFF, 32'h0000_0001);   // R7 R8 zero with carry
    step(1, 0, 0, 32'h0000_FFFF, 32'h0000_0001);   // R3 carry across halves
    step(1, 0, 0, 32'h7FFF_FFFF, 32'h0000_0001);   // R10 positive overflow
    step(1, 1, 0, 32'h0000_0005, 32'h0000_0005);   // R5 R8 equal subtract, no borrow
    step(1, 1, 0, 32'h0000_0003, 32'h0000_0005);   // R8 R9 borrow and negative
    step(1, 1, 0, 32'h8000_0000, 32'h0000_0001);   // R10 negative overflow on subtract
    step(0, 0, 0, 32'h1234_5678, 32'h1111_1111);   // R12 idle gives no result
    step(1, 0, 0, 32'h0000_FFF0, 32'h0000_0008);   // R6 chain start
    step(1, 0, 1, 32'hDEAD_BEEF, 32'h0000_0010);   // R6 forwarded, in_a ignored
    step(1, 0, 1, 32'h0000_0000, 32'h0001_FFFF);   // R6 forwarded with low carry
    step(1, 1, 1, 32'hFFFF_FFFF, 32'h0000_0001);   // R6 forwarded subtract
    // constrained random
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a, b;
      int k;
      k = $urandom % 4;
      a = (k == 0) ? {16'h0000, 16'hFFFF} : (k == 1) ? 32'h8000_0000 ^ $urandom : $urandom;
      b = ($urandom % 5 == 0) ? {$urandom % 2 == 0 ? 16'hFFFF : 16'h0000, 16'h0001} : $urandom;
      step(($urandom % 8) != 0, $urandom % 2 == 1, $urandom % 2 == 1, a, b);
    end
    repeat (4) step(0, 0, 0, 32'd0, 32'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule